// File: doc/BRIEF.md
# Serial Port with Deep Receive Buffer and Clear-to-Send Flow Control

This block is a memory-mapped serial port for a small system-on-chip. It has a transmitter and a receiver. Both use a bit period that is fixed when the design is built. The divisor equals the clock frequency divided by the bit rate, so a 18 MHz clock and 62500 bit/s give 288. The data-bit count and the stop-bit count are also build-time parameters.

Incoming bytes go into a deep receive FIFO (512 entries by default). Software can therefore leave bytes waiting and collect them later. Software can read the current fill level at any time.

A simple single-cycle register bus gives access to receive status, receive data, the receive fill count, transmit status and transmit data. Flow control uses two active-low clear-to-send lines:
- The input holds back any new transmit frame while it is high.
- The output goes high while the receive FIFO is full.

Top module: `uart_flowbuf`

## Requirements
- R1: After reset, `tx_line` is high, `cts_out_n` is low, the fill count reads 0, receive status reads 0 and transmit status reads 1.
- R2: A transmitted frame is one low start bit, then DATA_BITS data bits sent least significant bit first, then STOP_BITS high stop bits, with every bit lasting DIVISOR clock cycles.
- R3: A byte written to transmit data (address 0x41) while `cts_in_n` is high is held back, and `tx_line` stays high. Its frame begins only after `cts_in_n` goes low.
- R4: Transmit status (address 0x40, bit 0) reads 1 only while the transmitter is idle. A write to 0x41 while that bit is 0 is ignored and produces no frame.
- R5: The receiver confirms a start bit half a bit period after the falling edge. It then samples each data bit one bit period apart, least significant bit first, and stores the assembled byte in the FIFO.
- R6: A low pulse on `rx_line` that has ended by the half-period check is rejected and stores nothing.
- R7: Receive status (address 0x20, bit 0) reads 1 when the FIFO holds at least one byte. Address 0x22 reads the number of bytes held.
- R8: A read of receive data (address 0x21) returns the oldest byte and removes it. Bytes leave in arrival order.
- R9: `cts_out_n` is high exactly while the FIFO holds FIFO_DEPTH bytes, and low otherwise.
- R10: A byte that arrives while the FIFO is full is dropped. The stored bytes and the count stay unchanged.
- R11: A frame whose stop bit is sampled low is discarded and stores nothing.
- R12: Reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_cs | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data (transmit byte) |
| bus_rdata | output | 16 | Read data, combinational from address |
| rx_line | input | 1 | Serial receive line, idle high |
| tx_line | output | 1 | Serial transmit line, idle high |
| cts_in_n | input | 1 | Active-low permission to start a transmit frame |
| cts_out_n | output | 1 | Active-low ready-to-accept, high when the FIFO is full |

## Verification
The bench builds the block with DIVISOR = 8, FIFO_DEPTH = 4, eight data bits and one stop bit. The short bit period keeps each frame to about 80 cycles, so many frames fit in one run, and the half-period glitch window stays only four cycles wide. The four-entry FIFO makes the full condition easy to reach, which brings `cts_out_n` rising and the dropping of an overflow byte into reach with a handful of frames.

// File: rtl/flowbuf_pkg.sv
package flowbuf_pkg;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_WAIT,
        TX_START,
        TX_DATA,
        TX_STOP
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_e;

endpackage

// File: rtl/flowbuf_fifo.sv
module flowbuf_fifo #(
    parameter int DEPTH = 512,
    parameter int WIDTH = 8,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [WIDTH-1:0] data_i,
    input  logic             pop_i,
    output logic [WIDTH-1:0] data_o,
    output logic [CW-1:0]    count_o,
    output logic             full_o,
    output logic             empty_o
);

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
    } fifo_state_t;

    fifo_state_t s_d, s_q;
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    assign full_o  = (s_q.cnt == CW'(DEPTH));
    assign empty_o = (s_q.cnt == '0);
    assign do_push = push_i && !full_o;
    assign do_pop  = pop_i && !empty_o;
    assign data_o  = mem_q[s_q.rd];
    assign count_o = s_q.cnt;

    always_comb begin
        s_d = s_q;
        if (do_push) begin
            s_d.wr = (s_q.wr == AW'(DEPTH - 1)) ? '0 : s_q.wr + 1'b1;
        end
        if (do_pop) begin
            s_d.rd = (s_q.rd == AW'(DEPTH - 1)) ? '0 : s_q.rd + 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   s_d.cnt = s_q.cnt + 1'b1;
            2'b01:   s_d.cnt = s_q.cnt - 1'b1;
            default: s_d.cnt = s_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem_q[s_q.wr] <= data_i;
        end
    end

    // R9: fill level never exceeds the depth
    a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CW'(DEPTH));

    // R10: a push into a full buffer without a pop leaves the count as it was
    a_r10_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && full_o && !pop_i) |=> (s_q.cnt == $past(s_q.cnt)));

endmodule

// File: rtl/flowbuf_tx.sv
module flowbuf_tx
    import flowbuf_pkg::*;
#(
    parameter int DIVISOR   = 288,
    parameter int DATA_BITS = 8,
    parameter int STOP_BITS = 1,
    localparam int CNTW = $clog2(DIVISOR + 1),
    localparam int BW   = $clog2(DATA_BITS + STOP_BITS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_i,
    input  logic [DATA_BITS-1:0] byte_i,
    input  logic                 cts_n_i,
    output logic                 ready_o,
    output logic                 line_o
);

    typedef struct packed {
        tx_state_e            st;
        logic [CNTW-1:0]      cnt;
        logic [BW-1:0]        bidx;
        logic [DATA_BITS-1:0] hold;
    } tx_regs_t;

    tx_regs_t r_d, r_q;
    logic     bit_end;
    logic [DATA_BITS-1:0] shifted;

    assign bit_end = (r_q.cnt == CNTW'(DIVISOR - 1));
    assign shifted = r_q.hold >> r_q.bidx;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            TX_IDLE: begin
                if (load_i) begin
                    r_d.hold = byte_i;
                    r_d.st   = TX_WAIT;
                end
            end
            TX_WAIT: begin
                if (!cts_n_i) begin
                    r_d.st  = TX_START;
                    r_d.cnt = '0;
                end
            end
            TX_START: begin
                if (bit_end) begin
                    r_d.cnt  = '0;
                    r_d.bidx = '0;
                    r_d.st   = TX_DATA;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            TX_DATA: begin
                if (bit_end) begin
                    r_d.cnt = '0;
                    if (r_q.bidx == BW'(DATA_BITS - 1)) begin
                        r_d.bidx = '0;
                        r_d.st   = TX_STOP;
                    end else begin
                        r_d.bidx = r_q.bidx + 1'b1;
                    end
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            TX_STOP: begin
                if (bit_end) begin
                    r_d.cnt = '0;
                    if (r_q.bidx == BW'(STOP_BITS - 1)) begin
                        r_d.bidx = '0;
                        r_d.st   = TX_IDLE;
                    end else begin
                        r_d.bidx = r_q.bidx + 1'b1;
                    end
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            default: r_d.st = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: TX_IDLE, cnt: '0, bidx: '0, hold: '0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        unique case (r_q.st)
            TX_START: line_o = 1'b0;
            TX_DATA:  line_o = shifted[0];
            default:  line_o = 1'b1;
        endcase
    end

    assign ready_o = (r_q.st == TX_IDLE);

    // R3: a frame only starts when clear-to-send was asserted the cycle before
    a_r3_cts_gate: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(line_o) |-> !$past(cts_n_i));

    // R4: a load while busy does not disturb the byte being sent
    a_r4_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !ready_o) |=> $stable(r_q.hold));

    // R2: the line is high whenever the transmitter is idle or waiting
    a_r2_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == TX_IDLE || r_q.st == TX_WAIT) |-> line_o);

endmodule

// File: rtl/flowbuf_rx.sv
module flowbuf_rx
    import flowbuf_pkg::*;
#(
    parameter int DIVISOR   = 288,
    parameter int DATA_BITS = 8,
    localparam int CNTW = $clog2(DIVISOR + 1),
    localparam int BW   = $clog2(DATA_BITS + 1),
    localparam int HALF = DIVISOR / 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 line_i,
    output logic                 valid_o,
    output logic [DATA_BITS-1:0] byte_o
);

    typedef struct packed {
        logic [1:0]           sync;
        rx_state_e            st;
        logic [CNTW-1:0]      cnt;
        logic [BW-1:0]        bidx;
        logic [DATA_BITS-1:0] shreg;
        logic                 valid;
    } rx_regs_t;

    rx_regs_t r_d, r_q;
    logic     rx_s;
    logic     bit_end;
    logic     half_end;

    assign rx_s     = r_q.sync[1];
    assign bit_end  = (r_q.cnt == CNTW'(DIVISOR - 1));
    assign half_end = (r_q.cnt == CNTW'(HALF - 1));

    always_comb begin
        r_d       = r_q;
        r_d.sync  = {r_q.sync[0], line_i};
        r_d.valid = 1'b0;
        unique case (r_q.st)
            RX_IDLE: begin
                if (!rx_s) begin
                    r_d.st  = RX_START;
                    r_d.cnt = '0;
                end
            end
            RX_START: begin
                if (half_end) begin
                    r_d.cnt = '0;
                    if (rx_s) begin
                        r_d.st = RX_IDLE;
                    end else begin
                        r_d.st   = RX_DATA;
                        r_d.bidx = '0;
                    end
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            RX_DATA: begin
                if (bit_end) begin
                    r_d.cnt   = '0;
                    r_d.shreg = DATA_BITS'({rx_s, r_q.shreg} >> 1);
                    if (r_q.bidx == BW'(DATA_BITS - 1)) begin
                        r_d.st = RX_STOP;
                    end else begin
                        r_d.bidx = r_q.bidx + 1'b1;
                    end
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            RX_STOP: begin
                if (bit_end) begin
                    r_d.cnt   = '0;
                    r_d.valid = rx_s;
                    r_d.st    = RX_IDLE;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            default: r_d.st = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{sync: 2'b11, st: RX_IDLE, cnt: '0, bidx: '0,
                     shreg: '0, valid: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign valid_o = r_q.valid;
    assign byte_o  = r_q.shreg;

    // R6: a start bit found high again at the half-period check is dropped
    a_r6_glitch_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == RX_START && half_end && rx_s) |=> (r_q.st == RX_IDLE && !valid_o));

    // R11: a byte is only delivered from the stop-bit state
    a_r11_valid_from_stop: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> ($past(r_q.st) == RX_STOP));

endmodule

// File: rtl/uart_flowbuf.sv
module uart_flowbuf #(
    parameter int DIVISOR    = 288,
    parameter int DATA_BITS  = 8,
    parameter int STOP_BITS  = 1,
    parameter int FIFO_DEPTH = 512,
    localparam int CW = $clog2(FIFO_DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_cs,
    input  logic        bus_we,
    input  logic [7:0]  bus_addr,
    input  logic [7:0]  bus_wdata,
    output logic [15:0] bus_rdata,
    input  logic        rx_line,
    output logic        tx_line,
    input  logic        cts_in_n,
    output logic        cts_out_n
);

    localparam logic [7:0] A_RX_STAT  = 8'h20;
    localparam logic [7:0] A_RX_DATA  = 8'h21;
    localparam logic [7:0] A_RX_COUNT = 8'h22;
    localparam logic [7:0] A_TX_STAT  = 8'h40;
    localparam logic [7:0] A_TX_DATA  = 8'h41;

    logic                 rx_valid;
    logic [DATA_BITS-1:0] rx_byte;
    logic [DATA_BITS-1:0] head;
    logic [CW-1:0]        count;
    logic                 full, empty;
    logic                 pop, tx_load, tx_ready;

    assign pop     = bus_cs && !bus_we && (bus_addr == A_RX_DATA);
    assign tx_load = bus_cs && bus_we && (bus_addr == A_TX_DATA);

    flowbuf_rx #(
        .DIVISOR   (DIVISOR),
        .DATA_BITS (DATA_BITS)
    ) rx_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_i  (rx_line),
        .valid_o (rx_valid),
        .byte_o  (rx_byte)
    );

    flowbuf_fifo #(
        .DEPTH (FIFO_DEPTH),
        .WIDTH (DATA_BITS)
    ) fifo_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (rx_valid),
        .data_i  (rx_byte),
        .pop_i   (pop),
        .data_o  (head),
        .count_o (count),
        .full_o  (full),
        .empty_o (empty)
    );

    flowbuf_tx #(
        .DIVISOR   (DIVISOR),
        .DATA_BITS (DATA_BITS),
        .STOP_BITS (STOP_BITS)
    ) tx_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (tx_load),
        .byte_i  (bus_wdata[DATA_BITS-1:0]),
        .cts_n_i (cts_in_n),
        .ready_o (tx_ready),
        .line_o  (tx_line)
    );

    assign cts_out_n = full;

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_RX_STAT:  bus_rdata[0] = !empty;
            A_RX_DATA:  bus_rdata[DATA_BITS-1:0] = empty ? '0 : head;
            A_RX_COUNT: bus_rdata[CW-1:0] = count;
            A_TX_STAT:  bus_rdata[0] = tx_ready;
            default:    bus_rdata = '0;
        endcase
    end

    // R10: a delivered byte meeting a full buffer with no read leaves the count unchanged
    a_r10_drop_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && cts_out_n && !pop) |=> $stable(count));

    // R8: a data read without a new arrival removes exactly one byte
    a_r8_pop_decrements: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !empty && !rx_valid) |=> (count == $past(count) - 1'b1));

    // R9: the flow-control output is high only at full depth
    a_r9_cts_out: assert property (@(posedge clk) disable iff (!rst_n)
        cts_out_n |-> (count == CW'(FIFO_DEPTH)));

endmodule

// File: tb/uart_flowbuf_tb_top.sv
module uart_flowbuf_tb_top;

    localparam int DIV   = 8;
    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_cs = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        rx_line = 1'b1;
    logic        tx_line;
    logic        cts_in_n = 1'b0;
    logic        cts_out_n;

    int checks = 0;
    int fails  = 0;
    int frames_seen = 0;
    bit finished = 1'b0;

    logic [7:0] rx_exp_q [$];
    logic [7:0] tx_exp_q [$];

    always #5 clk = ~clk;

    uart_flowbuf #(
        .DIVISOR    (DIV),
        .DATA_BITS  (8),
        .STOP_BITS  (1),
        .FIFO_DEPTH (DEPTH)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_cs    (bus_cs),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .rx_line   (rx_line),
        .tx_line   (tx_line),
        .cts_in_n  (cts_in_n),
        .cts_out_n (cts_out_n)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [15:0] v);
        @(negedge clk);
        bus_cs = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_cs = 1'b0;
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_cs = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_cs = 1'b0; bus_we = 1'b0;
    endtask

    // driver: send one frame on rx_line; expect it stored if push_exp
    task automatic send_rx(input logic [7:0] b, input bit stop_val, input bit push_exp);
        @(negedge clk);
        rx_line = 1'b0;
        repeat (DIV) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx_line = b[i];
            repeat (DIV) @(negedge clk);
        end
        rx_line = stop_val;
        repeat (DIV) @(negedge clk);
        rx_line = 1'b1;
        repeat (6) @(negedge clk);
        if (push_exp) rx_exp_q.push_back(b);
    endtask

    // scoreboard read side: pop one byte and compare with the oldest expected
    task automatic read_compare(input string req);
        logic [15:0] v;
        logic [7:0]  e;
        bus_read(8'h21, v);
        e = (rx_exp_q.size() > 0) ? rx_exp_q.pop_front() : 8'h00;
        check(v[7:0] == e, req, v, e);
    endtask

    task automatic tx_send(input logic [7:0] b);
        tx_exp_q.push_back(b);
        bus_write(8'h41, b);
    endtask

    task automatic wait_tx_ready();
        logic [15:0] v;
        v = '0;
        for (int i = 0; i < 400 && v[0] == 1'b0; i++) bus_read(8'h40, v);
    endtask

    // monitor for the transmit line
    initial begin
        logic [7:0] got;
        logic [7:0] e;
        forever begin
            @(negedge clk);
            if (rst_n && tx_line === 1'b0) begin
                repeat (DIV / 2) @(negedge clk);
                check(tx_line == 1'b0, "R2 start bit", tx_line, 0);
                for (int i = 0; i < 8; i++) begin
                    repeat (DIV) @(negedge clk);
                    got[i] = tx_line;
                end
                repeat (DIV) @(negedge clk);
                check(tx_line == 1'b1, "R2 stop bit", tx_line, 1);
                frames_seen++;
                if (tx_exp_q.size() == 0) begin
                    check(1'b0, "R4 unexpected frame", got, 0);
                end else begin
                    e = tx_exp_q.pop_front();
                    check(got == e, "R2 frame data", got, e);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(tx_line == 1'b1, "R1 tx_line", tx_line, 1);
        check(cts_out_n == 1'b0, "R1 cts_out_n", cts_out_n, 0);
        bus_read(8'h22, v); check(v == 0, "R1 count", v, 0);
        bus_read(8'h20, v); check(v == 0, "R1 rx status", v, 0);
        bus_read(8'h40, v); check(v == 1, "R1 tx status", v, 1);

        // R12 unmapped
        bus_read(8'h30, v); check(v == 0, "R12 unmapped", v, 0);

        // R5/R7/R8 receive two bytes
        send_rx(8'hA5, 1'b1, 1'b1);
        send_rx(8'h3C, 1'b1, 1'b1);
        bus_read(8'h20, v); check(v == 1, "R7 rx status", v, 1);
        bus_read(8'h22, v); check(v == 2, "R7 count", v, 2);
        read_compare("R5 first byte");
        bus_read(8'h22, v); check(v == 1, "R8 count after pop", v, 1);
        read_compare("R8 order");
        bus_read(8'h20, v); check(v == 0, "R7 empty status", v, 0);

        // R6 glitch
        @(negedge clk); rx_line = 1'b0;
        repeat (2) @(negedge clk); rx_line = 1'b1;
        repeat (3 * DIV) @(negedge clk);
        bus_read(8'h22, v); check(v == 0, "R6 glitch count", v, 0);

        // R11 bad stop bit
        send_rx(8'h81, 1'b0, 1'b0);
        repeat (DIV) @(negedge clk);
        bus_read(8'h22, v); check(v == 0, "R11 framing count", v, 0);

        // R9/R10 fill the buffer
        send_rx(8'h11, 1'b1, 1'b1);
        send_rx(8'h22, 1'b1, 1'b1);
        send_rx(8'h33, 1'b1, 1'b1);
        check(cts_out_n == 1'b0, "R9 not yet full", cts_out_n, 0);
        send_rx(8'h44, 1'b1, 1'b1);
        check(cts_out_n == 1'b1, "R9 full", cts_out_n, 1);
        send_rx(8'hEE, 1'b1, 1'b0);
        bus_read(8'h22, v); check(v == DEPTH, "R10 count", v, DEPTH);
        for (int i = 0; i < DEPTH; i++) read_compare("R10 contents");
        check(cts_out_n == 1'b0, "R9 drained", cts_out_n, 0);
        bus_read(8'h20, v); check(v == 0, "R10 overflow byte absent", v, 0);

        // R2 transmit
        cts_in_n = 1'b0;
        tx_send(8'h96);
        wait_tx_ready();
        tx_send(8'h01);
        wait_tx_ready();
        repeat (4) @(negedge clk);
        check(frames_seen == 2, "R2 frames", frames_seen, 2);

        // R3 hold while cts_in_n high
        cts_in_n = 1'b1;
        tx_send(8'h5A);
        bus_read(8'h40, v); check(v == 0, "R3 busy status", v, 0);
        for (int i = 0; i < 5 * DIV; i++) begin
            @(negedge clk);
            if (tx_line != 1'b1) check(1'b0, "R3 line held", tx_line, 1);
        end
        check(frames_seen == 2, "R3 no frame yet", frames_seen, 2);
        cts_in_n = 1'b0;
        repeat (3 * DIV) @(negedge clk);

        // R4 write while busy is ignored
        bus_write(8'h41, 8'hFF);
        wait_tx_ready();
        repeat (15 * DIV) @(negedge clk);
        check(frames_seen == 3, "R4 frames", frames_seen, 3);
        check(tx_exp_q.size() == 0, "R4 queue", tx_exp_q.size(), 0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule